// File: doc/BRIEF.md
# UART transmitter with break generation

This block serialises one data word at a time onto an asynchronous line. A word is written into a one-deep holding register with a write strobe. When the transmitter is free, the word moves into the shift register. It is then sent as a frame: a low start bit, then 8 or 9 data bits least-significant first, where an optional parity bit replaces the last data bit, then a high stop bit. The frame advances by one bit for each pulse on the bit-rate enable input. The enable comes from an outside divider.

A sticky send-break input makes the transmitter send all-zero break characters, back to back, for as long as the input is held. Each break lasts as many bit times as a full frame in the selected length mode. When the input is released, the transmitter finishes the break in progress and then drives one marking bit. Only after that can a start bit follow. A word written while a break is pending waits until the break and its marking bit are done. An inversion control flips every bit on the line, including the idle level.

The control states are idle (line marking, waiting), start, data (data and parity bits), stop, break (zero bit times) and mark (the single '1' after a break). From idle, stop or mark, each tick takes the transmitter to one of three states. It goes to break if send-break is set. Otherwise it goes to start if a word is waiting, and to idle if neither holds. Start leads to data. Data leads to stop after the last data bit. Break either repeats itself or, once send-break is released, leads to mark.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line is at its marking level, `empty` is 1 and `done` is 1.
- R2: With `mode9`=0 and `par_en`=0 a frame is one '0' start bit, the 8 bits of `wr_data` LSB first, and one '1' stop bit. The line changes only on a clock where `bit_tick` is 1, and holds each bit for exactly one tick period.
- R3: With `mode9`=1 the frame carries 9 data bits, and the ninth bit, sent last, is `wr_bit8`.
- R4: With `par_en`=1 a parity bit takes the place of the last data bit (bit 7, or bit 8 in 9-bit mode). It makes the count of ones over the sent data and parity bits even when `par_odd`=0 and odd when `par_odd`=1.
- R5: With `inv_out`=1, `txd` is the complement of the uninverted line for every bit, idle included.
- R6: `empty` goes to 0 on the clock after a write. It returns to 1 on the clock after the tick on which the word enters the shift register, which is the tick where its start bit begins.
- R7: `done` is 1 only while the transmitter is idle, no word is waiting and `send_brk` is 0.
- R8: While `send_brk` is 1 the line carries zero bits continuously. Each break character is 10 bit times long with `mode9`=0 and 11 with `mode9`=1.
- R9: After `send_brk` falls, the break in progress runs to its full length, and then exactly one '1' bit is sent before the next decision.
- R10: A word written while a break is pending is sent only after the break and its marking bit.
- R11: A word waiting when a stop bit ends starts its start bit on the very next tick, with no idle bit between frames.
- R12: A send-break raised during a normal frame takes effect only after that frame's stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-rate enable, one clock wide |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Low data bits of the word |
| wr_bit8 | input | 1 | Ninth data bit |
| mode9 | input | 1 | 1 selects 9 data bits |
| par_en | input | 1 | 1 enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| inv_out | input | 1 | 1 inverts every line bit |
| send_brk | input | 1 | Sticky send-break control |
| txd | output | 1 | Serial line output |
| empty | output | 1 | Holding register empty |
| done | output | 1 | Transmission complete |

## Verification
A wrong state or bit counter shows up at `txd` on the next bit time as a bit that is too many, too few, or has the wrong value. A break that is too short, or a missing marking bit, changes the line level one tick early. A lost or duplicated holding-register flag shows on `empty` one clock after the write or the load, and on `done` in the same clock. The bench model predicts all three outputs every clock, so any such fault shows up no later than one bit time after the bad state arises.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK,
        ST_MARK
    } tx_state_t;

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_en) begin
                full <= 1'b1;
                word <= wr_word;
            end
        end
    end

    // R6: a write always leaves a word waiting
    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);

endmodule

// File: rtl/uart_brk_parity.sv
module uart_brk_parity #(
    parameter int WORD_W = 9
) (
    input  logic [WORD_W-1:0] word,
    input  logic              mode9,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [WORD_W-1:0] shaped
);

    localparam int NB_LONG  = WORD_W;
    localparam int NB_SHORT = WORD_W - 1;

    int   nb;
    logic acc;

    always_comb begin
        nb     = mode9 ? NB_LONG : NB_SHORT;
        acc    = 1'b0;
        shaped = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < nb) begin
                shaped[i] = word[i];
                if (i < nb - 1)
                    acc = acc ^ word[i];
            end
        end
        if (par_en)
            shaped[nb-1] = acc ^ par_odd;
    end

endmodule

// File: rtl/uart_brk_fsm.sv
module uart_brk_fsm
    import uart_brk_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              send_brk,
    input  logic              mode9,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] shaped,
    output logic              take,
    output logic              line,
    output logic              idle
);

    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] DATA_LAST_S = CNT_W'(WORD_W - 2);
    localparam logic [CNT_W-1:0] DATA_LAST_L = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] BRK_LAST_S  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] BRK_LAST_L  = CNT_W'(WORD_W + 1);

    tx_state_t         state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [WORD_W-1:0] sh, sh_n;
    logic [CNT_W-1:0]  data_last, brk_last;

    assign data_last = mode9 ? DATA_LAST_L : DATA_LAST_S;
    assign brk_last  = mode9 ? BRK_LAST_L  : BRK_LAST_S;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            sh    <= sh_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sh_n    = sh;
        take    = 1'b0;
        if (bit_tick) begin
            unique case (state)
                ST_IDLE, ST_STOP, ST_MARK: begin
                    if (send_brk) begin
                        state_n = ST_BREAK;
                        cnt_n   = '0;
                    end else if (hold_full) begin
                        state_n = ST_START;
                        sh_n    = shaped;
                        take    = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                ST_START: begin
                    state_n = ST_DATA;
                    cnt_n   = '0;
                end
                ST_DATA: begin
                    sh_n = sh >> 1;
                    if (cnt == data_last)
                        state_n = ST_STOP;
                    else
                        cnt_n = cnt + 1'b1;
                end
                ST_BREAK: begin
                    if (cnt == brk_last) begin
                        cnt_n = '0;
                        if (!send_brk)
                            state_n = ST_MARK;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        line = 1'b1;
        idle = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_START: line = 1'b0;
            ST_DATA:  line = sh[0];
            ST_STOP:  line = 1'b1;
            ST_BREAK: line = 1'b0;
            ST_MARK:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end

    // R2: state moves only on a bit tick
    p_tick_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(state));

    // R9: leaving a break always passes through the marking bit
    p_mark_after_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_BREAK && state != ST_BREAK) |-> state == ST_MARK);

    // R6: a start bit begins only when a word was waiting
    p_start_needs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> $past(hold_full));

    // R8: break counter stays inside the longest break
    p_brk_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BREAK |-> cnt <= BRK_LAST_L);

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit8,
    input  logic              mode9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              inv_out,
    input  logic              send_brk,
    output logic              txd,
    output logic              empty,
    output logic              done
);

    localparam int WORD_W = DATA_W + 1;

    logic              full, take, line, idle;
    logic [WORD_W-1:0] word, shaped;

    uart_brk_hold #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word ({wr_bit8, wr_data}),
        .take    (take),
        .full    (full),
        .word    (word)
    );

    uart_brk_parity #(.WORD_W(WORD_W)) u_par (
        .word    (word),
        .mode9   (mode9),
        .par_en  (par_en),
        .par_odd (par_odd),
        .shaped  (shaped)
    );

    uart_brk_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .send_brk  (send_brk),
        .mode9     (mode9),
        .hold_full (full),
        .shaped    (shaped),
        .take      (take),
        .line      (line),
        .idle      (idle)
    );

    assign txd   = line ^ inv_out;
    assign empty = !full;
    assign done  = idle && !full && !send_brk;

    // R7: completion implies the line is at its marking level
    p_done_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (txd != inv_out));

endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;

    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_bit8 = 1'b0;
    logic       mode9 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       inv_out = 1'b0;
    logic       send_brk = 1'b0;
    logic       txd, empty, done;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    uart_brk_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_bit8(wr_bit8), .mode9(mode9), .par_en(par_en),
        .par_odd(par_odd), .inv_out(inv_out), .send_brk(send_brk),
        .txd(txd), .empty(empty), .done(done)
    );

    // bit-rate tick, one clock in TICK_DIV
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv     = (tdiv + 1) % TICK_DIV;
        bit_tick = (tdiv == 0);
    end

    // behavioural reference model
    bit       m_cur, m_idle, m_brk, m_full;
    bit [8:0] m_word;
    bit       q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 1; m_idle = 1; m_brk = 0; m_full = 0; m_word = '0;
            q.delete();
        end else begin
            if (bit_tick) begin
                int flen, nb, ones;
                bit b;
                flen = mode9 ? 11 : 10;
                nb   = mode9 ? 9 : 8;
                if (q.size() > 0) begin
                    m_cur = q.pop_front();
                end else if (m_brk && !send_brk) begin
                    m_brk = 0; m_cur = 1; m_idle = 0;
                end else if (send_brk) begin
                    m_brk = 1; m_idle = 0; m_cur = 0;
                    for (int k = 1; k < flen; k++) q.push_back(1'b0);
                end else if (m_full) begin
                    m_full = 0; m_idle = 0; m_cur = 0;
                    ones = 0;
                    for (int k = 0; k < nb; k++) begin
                        b = m_word[k];
                        if (par_en && k == nb - 1)
                            b = (ones % 2 == 1) ^ par_odd;
                        else
                            ones += b;
                        q.push_back(b);
                    end
                    q.push_back(1'b1);
                end else begin
                    m_cur = 1; m_idle = 1;
                end
            end
            if (wr_en) begin
                m_full = 1;
                m_word = {wr_bit8, wr_data};
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (txd !== (m_cur ^ inv_out)) begin
                bad++;
                $display("FAIL %s txd actual=%b expected=%b t=%0t", cur_req, txd, m_cur ^ inv_out, $time);
            end
            if (empty !== !m_full) begin
                bad++;
                $display("FAIL R6 empty actual=%b expected=%b t=%0t", empty, !m_full, $time);
            end
            if (done !== (m_idle && !m_full && !send_brk)) begin
                bad++;
                $display("FAIL R7 done actual=%b expected=%b t=%0t", done, m_idle && !m_full && !send_brk, $time);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(int n);
        step(n * TICK_DIV);
    endtask

    task automatic put(input logic [7:0] d, input logic b8);
        @(posedge clk); #1;
        wr_en = 1; wr_data = d; wr_bit8 = b8;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wait_empty();
        while (!empty) step(1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        step(5);
        rst_n = 1;
        step(1);
        @(negedge clk);
        total++;
        if (txd !== 1'b1 || empty !== 1'b1 || done !== 1'b1) begin
            bad++;
            $display("FAIL R1 reset actual=%b%b%b expected=111", txd, empty, done);
        end
        step(1);

        cur_req = "R2"; put(8'hA5, 0); ticks(14);
        put(8'h3C, 0); ticks(14);

        cur_req = "R11"; put(8'h81, 0); wait_empty(); put(8'h7E, 0); ticks(26);

        cur_req = "R3"; mode9 = 1; put(8'h55, 1); ticks(14); put(8'hFF, 0); ticks(14);

        cur_req = "R4"; par_en = 1; par_odd = 0; put(8'h13, 1); ticks(14);
        par_odd = 1; put(8'h13, 1); ticks(14);
        mode9 = 0; put(8'hC7, 0); ticks(13); par_odd = 0; put(8'hC7, 0); ticks(13);
        par_en = 0;

        cur_req = "R5"; inv_out = 1; ticks(2); put(8'h96, 0); ticks(14); inv_out = 0; ticks(2);

        cur_req = "R8"; send_brk = 1; ticks(25);
        cur_req = "R10"; put(8'h5A, 0); ticks(3);
        cur_req = "R9"; send_brk = 0; ticks(20);

        cur_req = "R8"; mode9 = 1; send_brk = 1; ticks(24);
        cur_req = "R9"; send_brk = 0; ticks(14);
        mode9 = 0;

        cur_req = "R12"; put(8'hF0, 0); ticks(3); send_brk = 1; ticks(20);
        send_brk = 0; ticks(14);

        cur_req = "R7"; send_brk = 1; step(3); send_brk = 0; ticks(14);

        summary();
    end

endmodule